// File: doc/BRIEF.md
# FIFO with coded fill-level status

A first-in first-out buffer over a simple dual-port memory of `2**ADDR_W` words. The `ASYNC` parameter picks the clocking. With `ASYNC=1` the write side runs on `push_clk` and the read side runs on `pop_clk`, and the pointers cross between the two domains as Gray code. With `ASYNC=0` both sides run on `push_clk` and `pop_clk` is ignored. A word offered with `push` is written on the rising edge of the write-side clock. An accepted `pop` puts the oldest word on `dout` one read-side clock edge later. `dout` holds its value between pops.

The block has no plain full or empty bits. Each side reports a 4-bit level code instead:
- `push_lvl` encodes the free space, as seen from the write side.
- `pop_lvl` encodes the stored entry count, as seen from the read side.

When more than one code would apply, the most specific code is driven. Two single-bit outputs give early warning: `almost_full` means exactly one slot is free, and `almost_empty` means exactly one word is stored.

Each side has a synchronous flush and a clock enable. An active-low asynchronous reset clears both pointers.

Top module: `fifo_lvl`

## Requirements
- R1: Words leave in the order they entered. The word taken by an accepted pop appears on `dout` after the next read-side rising edge. `dout` is unchanged when no pop is accepted.
- R2: The coarse write-side codes, with free space `F` and depth `D`:
  - `F=0` gives 0000.
  - `F=D` gives 0001.
  - `F>D/2` gives 0010.
  - `F>D/4` gives 0011.
  - `64<=F<=D/4` gives 0100.
- R3: The fine write-side codes, for `1<=F<=63`:
  - `F=1` gives 1111.
  - `2<=F<=3` gives 1110.
  - `4<=F<=7` gives 1101.
  - `8<=F<=15` gives 1100.
  - `16<=F<=31` gives 1011.
  - `32<=F<=63` gives 1010.
- R4: The low-occupancy read-side codes, with count `C` and `1<=C<=63`:
  - `C=0` gives 0000.
  - `C=1` gives 0001.
  - `C>=2` gives 0010.
  - `C>=4` gives 0011.
  - `C>=8` gives 0100.
  - `C>=16` gives 0101.
  - `C>=32` gives 0110.
- R5: The high-occupancy read-side codes:
  - `C=D` gives 1111.
  - `C>=D/2` gives 1110.
  - `C>=D/4` gives 1101.
  - `64<=C<D/4` gives 1000.
- R6: The write side only ever drives 0000–0100 or 1010–1111. The read side only ever drives 0000–0110, 1000 or 1101–1111.
- R7: A push while the write side sees zero free space is ignored. No stored word is overwritten and the level does not move.
- R8: A pop while the read side sees zero entries is ignored. `dout` keeps its value and the next pushed word is the next one read.
- R9: `almost_full` is high exactly when the write side sees one free slot. `almost_empty` is high exactly when the read side sees one stored word.
- R10: Flushes discard stored words.
  - `pop_flush` discards every word the read side has seen.
  - `push_flush` does the same. With `ASYNC=0` it acts in the same cycle, and a push on that edge is kept. With `ASYNC=1` the request is handed over to the read side first.
- R11: While `push_ce` is low, `push` and `push_flush` are ignored. While `pop_ce` is low, `pop` and `pop_flush` are ignored.
- R12: Driving `arst_n` low empties the FIFO at once, with no clock edge: `push_lvl` shows 0001 and `pop_lvl` shows 0000.
- R13: With `ASYNC=1` and unrelated clocks, the data and its order survive the crossing. After a few cycles of each destination clock, both codes settle to the true level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| push_clk | input | 1 | Write-side clock; also the only clock when ASYNC=0 |
| pop_clk | input | 1 | Read-side clock when ASYNC=1 |
| arst_n | input | 1 | Asynchronous active-low pointer reset |
| push_ce | input | 1 | Write-side clock enable |
| pop_ce | input | 1 | Read-side clock enable |
| push_flush | input | 1 | Synchronous flush request from the write side |
| pop_flush | input | 1 | Synchronous flush on the read side |
| push | input | 1 | Write request |
| din | input | DATA_W | Write data |
| pop | input | 1 | Read request |
| dout | output | DATA_W | Read data, valid one read edge after an accepted pop |
| push_lvl | output | 4 | Free-space code |
| pop_lvl | output | 4 | Occupancy code |
| almost_full | output | 1 | One free slot left |
| almost_empty | output | 1 | One word stored |

## Verification
The bench fills a 512-deep FIFO one word at a time and then drains it. It compares both level codes against every count from 0 to 512. A decoder with an off-by-one on a threshold shows up at the exact count where it is wrong: for example 0011 reported at 128 free instead of 129, or 1000 reported at a quarter full.

The bench pushes into a full FIFO and pops from an empty one. A design that moved its pointers in those cases would corrupt the drained sequence, or return stale data after the next push.

The flush tests cover a push on the same edge as a flush, and flushes with the clock enable low. The asynchronous reset is checked before any clock edge. A second instance, with unrelated clocks, checks that Gray-coded crossing keeps data order and that the codes settle.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;

  // Free-space code seen by the writer; most specific range wins.
  function automatic logic [3:0] lvl_push_code(int unsigned free_n, int unsigned depth);
    if (free_n == 0)              return 4'b0000;
    else if (free_n == depth)     return 4'b0001;
    else if (free_n * 2 > depth)  return 4'b0010;
    else if (free_n * 4 > depth)  return 4'b0011;
    else if (free_n >= 64)        return 4'b0100;
    else if (free_n >= 32)        return 4'b1010;
    else if (free_n >= 16)        return 4'b1011;
    else if (free_n >= 8)         return 4'b1100;
    else if (free_n >= 4)         return 4'b1101;
    else if (free_n >= 2)         return 4'b1110;
    else                          return 4'b1111;
  endfunction

  // Occupancy code seen by the reader; most specific range wins.
  function automatic logic [3:0] lvl_pop_code(int unsigned cnt, int unsigned depth);
    if (cnt == 0)                 return 4'b0000;
    else if (cnt == depth)        return 4'b1111;
    else if (cnt * 2 >= depth)    return 4'b1110;
    else if (cnt * 4 >= depth)    return 4'b1101;
    else if (cnt >= 64)           return 4'b1000;
    else if (cnt >= 32)           return 4'b0110;
    else if (cnt >= 16)           return 4'b0101;
    else if (cnt >= 8)            return 4'b0100;
    else if (cnt >= 4)            return 4'b0011;
    else if (cnt >= 2)            return 4'b0010;
    else                          return 4'b0001;
  endfunction

  function automatic logic [31:0] lvl_gray2bin(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/fifo_lvl_ram.sv
module fifo_lvl_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 9
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_lvl_xsync.sv
module fifo_lvl_xsync
  import fifo_lvl_pkg::*;
#(
  parameter int W     = 10,
  parameter bit ASYNC = 1'b1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_gray,
  output logic [W-1:0] q_bin
);
  if (ASYNC) begin : g_cdc
    logic [W-1:0] s1, s2;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        s1 <= '0;
        s2 <= '0;
      end else begin
        s1 <= d_gray;
        s2 <= s1;
      end
    end
    assign q_bin = W'(lvl_gray2bin(32'(s2)));
  end else begin : g_direct
    assign q_bin = W'(lvl_gray2bin(32'(d_gray)));
  end
endmodule

// File: rtl/fifo_lvl.sv
module fifo_lvl
  import fifo_lvl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 9,
  parameter bit ASYNC  = 1'b1
) (
  input  logic              push_clk,
  input  logic              pop_clk,
  input  logic              arst_n,
  input  logic              push_ce,
  input  logic              pop_ce,
  input  logic              push_flush,
  input  logic              pop_flush,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [3:0]        push_lvl,
  output logic [3:0]        pop_lvl,
  output logic              almost_full,
  output logic              almost_empty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;
  typedef logic [PW-1:0] ptr_t;

  logic rd_clk;
  assign rd_clk = ASYNC ? pop_clk : push_clk;

  ptr_t w_bin, w_gray, r_bin, r_gray;
  ptr_t r_in_w, w_in_r;
  ptr_t w_count, r_count;
  logic w_full, r_empty;
  logic push_take, pop_take, flush_r, push_flush_xfer;

  // ---------------- write side ----------------
  assign w_count   = w_bin - r_in_w;
  assign w_full    = (w_count == ptr_t'(DEPTH));
  assign push_take = push_ce && push && !w_full;

  always_ff @(posedge push_clk or negedge arst_n) begin
    if (!arst_n) begin
      w_bin  <= '0;
      w_gray <= '0;
    end else if (push_take) begin
      w_bin  <= w_bin + ptr_t'(1);
      w_gray <= (w_bin + ptr_t'(1)) ^ ((w_bin + ptr_t'(1)) >> 1);
    end
  end

  assign push_lvl    = lvl_push_code(32'(DEPTH) - 32'(w_count), DEPTH);
  assign almost_full = (w_count == ptr_t'(DEPTH - 1));

  // ---------------- flush hand-over ----------------
  if (ASYNC) begin : g_fx
    logic       tog;
    logic [2:0] s;
    always_ff @(posedge push_clk or negedge arst_n) begin
      if (!arst_n)                     tog <= 1'b0;
      else if (push_ce && push_flush)  tog <= ~tog;
    end
    always_ff @(posedge rd_clk or negedge arst_n) begin
      if (!arst_n) s <= '0;
      else         s <= {s[1:0], tog};
    end
    assign push_flush_xfer = s[2] ^ s[1];
  end else begin : g_fx
    assign push_flush_xfer = push_ce & push_flush;
  end

  // ---------------- read side ----------------
  assign r_count  = w_in_r - r_bin;
  assign r_empty  = (r_count == '0);
  assign flush_r  = (pop_ce && pop_flush) || push_flush_xfer;
  assign pop_take = pop_ce && pop && !r_empty && !flush_r;

  always_ff @(posedge rd_clk or negedge arst_n) begin
    if (!arst_n) begin
      r_bin  <= '0;
      r_gray <= '0;
    end else if (flush_r) begin
      r_bin  <= w_in_r;
      r_gray <= w_in_r ^ (w_in_r >> 1);
    end else if (pop_take) begin
      r_bin  <= r_bin + ptr_t'(1);
      r_gray <= (r_bin + ptr_t'(1)) ^ ((r_bin + ptr_t'(1)) >> 1);
    end
  end

  assign pop_lvl      = lvl_pop_code(32'(r_count), DEPTH);
  assign almost_empty = (r_count == ptr_t'(1));

  // ---------------- pointer crossings ----------------
  fifo_lvl_xsync #(.W(PW), .ASYNC(ASYNC)) u_r2w (
    .clk(push_clk), .arst_n(arst_n), .d_gray(r_gray), .q_bin(r_in_w)
  );
  fifo_lvl_xsync #(.W(PW), .ASYNC(ASYNC)) u_w2r (
    .clk(rd_clk), .arst_n(arst_n), .d_gray(w_gray), .q_bin(w_in_r)
  );

  // ---------------- storage ----------------
  fifo_lvl_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(push_clk), .we(push_take), .waddr(w_bin[ADDR_W-1:0]), .wdata(din),
    .rclk(rd_clk), .re(pop_take), .raddr(r_bin[ADDR_W-1:0]), .rdata(dout)
  );

  // ---------------- assertions ----------------
  assert_no_overflow_R7: assert property (@(posedge push_clk) disable iff (!arst_n)
    (push && w_full) |=> (w_bin == $past(w_bin)));

  assert_no_underflow_R8: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (pop && r_empty && !flush_r) |=> (r_bin == $past(r_bin)));

  assert_pop_step_R1: assert property (@(posedge rd_clk) disable iff (!arst_n)
    pop_take |=> (r_bin == $past(r_bin) + ptr_t'(1)));

  assert_count_bound_R2: assert property (@(posedge push_clk) disable iff (!arst_n)
    (w_count <= ptr_t'(DEPTH)));

  assert_count_bound_R5: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (r_count <= ptr_t'(DEPTH)));

  assert_almost_full_R9: assert property (@(posedge push_clk) disable iff (!arst_n)
    almost_full |-> (push_lvl == 4'b1111));

  assert_almost_empty_R9: assert property (@(posedge rd_clk) disable iff (!arst_n)
    almost_empty |-> (pop_lvl == 4'b0001));

  assert_push_codes_R6: assert property (@(posedge push_clk) disable iff (!arst_n)
    push_lvl inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100,
                     4'b1010, 4'b1011, 4'b1100, 4'b1101, 4'b1110, 4'b1111});

  assert_pop_codes_R6: assert property (@(posedge rd_clk) disable iff (!arst_n)
    pop_lvl inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101,
                    4'b0110, 4'b1000, 4'b1101, 4'b1110, 4'b1111});
endmodule

// File: tb/fifo_lvl_tb.sv
module fifo_lvl_tb;
  localparam int D = 512;

  int tests = 0, fails = 0;
  logic clk = 0, pclk = 0;
  always #4 clk = ~clk;
  always #5.5 pclk = ~pclk;

  // synchronous instance
  logic arst_n = 0, push_ce = 1, pop_ce = 1, push_flush = 0, pop_flush = 0, push = 0, pop = 0;
  logic [15:0] din = 0, dout;
  logic [3:0] push_lvl, pop_lvl;
  logic almost_full, almost_empty;

  fifo_lvl #(.DATA_W(16), .ADDR_W(9), .ASYNC(1'b0)) u_dut (
    .push_clk(clk), .pop_clk(clk), .arst_n(arst_n), .push_ce(push_ce), .pop_ce(pop_ce),
    .push_flush(push_flush), .pop_flush(pop_flush), .push(push), .din(din), .pop(pop),
    .dout(dout), .push_lvl(push_lvl), .pop_lvl(pop_lvl),
    .almost_full(almost_full), .almost_empty(almost_empty));

  // asynchronous instance
  logic a_rst_n = 0, a_pf = 0, a_push = 0, a_pop = 0;
  logic [15:0] a_din = 0, a_dout;
  logic [3:0] a_plvl, a_qlvl;
  logic a_af, a_ae;

  fifo_lvl #(.DATA_W(16), .ADDR_W(9), .ASYNC(1'b1)) u_dut_async (
    .push_clk(clk), .pop_clk(pclk), .arst_n(a_rst_n), .push_ce(1'b1), .pop_ce(1'b1),
    .push_flush(a_pf), .pop_flush(1'b0), .push(a_push), .din(a_din), .pop(a_pop),
    .dout(a_dout), .push_lvl(a_plvl), .pop_lvl(a_qlvl),
    .almost_full(a_af), .almost_empty(a_ae));

  function automatic int flog2(int v);
    int r = 0;
    while (v > 1) begin v = v / 2; r++; end
    return r;
  endfunction

  function automatic logic [3:0] exp_push(int fr);
    if (fr == 0) return 4'h0;
    if (fr == D) return 4'h1;
    if (fr > D / 2) return 4'h2;
    if (fr > D / 4) return 4'h3;
    if (fr >= 64) return 4'h4;
    return 4'(15 - flog2(fr));
  endfunction

  function automatic logic [3:0] exp_pop(int c);
    if (c == 0) return 4'h0;
    if (c == D) return 4'hF;
    if (c >= D / 2) return 4'hE;
    if (c >= D / 4) return 4'hD;
    if (c >= 64) return 4'h8;
    return 4'(flog2(c) + 1);
  endfunction

  function automatic logic [15:0] pat(int n);
    return 16'(n * 37 + 5);
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one synchronous cycle with the given requests
  task automatic cyc(logic p, logic [15:0] d, logic q, logic pfl, logic qfl);
    @(negedge clk);
    push = p; din = d; pop = q; push_flush = pfl; pop_flush = qfl;
    @(posedge clk);
    #1;
    push = 0; pop = 0; push_flush = 0; pop_flush = 0;
  endtask

  initial begin
    #1600000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] push_seen, pop_seen;
    push_seen = 0; pop_seen = 0;
    #20;
    // R12 reset state
    chk("R12 push_lvl in reset", int'(push_lvl), 1);
    chk("R12 pop_lvl in reset", int'(pop_lvl), 0);
    chk("R9 almost_full in reset", int'(almost_full), 0);
    chk("R9 almost_empty in reset", int'(almost_empty), 0);
    @(negedge clk); arst_n = 1; a_rst_n = 1;

    // fill sweep
    for (int n = 1; n <= D; n++) begin
      cyc(1, pat(n - 1), 0, 0, 0);
      chk((D - n) < 64 ? "R3 push code" : "R2 push code", int'(push_lvl), int'(exp_push(D - n)));
      chk(n < 64 ? "R4 pop code" : "R5 pop code", int'(pop_lvl), int'(exp_pop(n)));
      chk("R9 almost_full", int'(almost_full), int'(D - n == 1));
      chk("R9 almost_empty", int'(almost_empty), int'(n == 1));
      push_seen[push_lvl] = 1'b1; pop_seen[pop_lvl] = 1'b1;
    end
    // R7 push while full
    cyc(1, 16'hDEAD, 0, 0, 0);
    chk("R7 push_lvl after push when full", int'(push_lvl), 0);
    chk("R7 pop_lvl after push when full", int'(pop_lvl), 15);

    // drain sweep
    for (int n = 0; n < D; n++) begin
      cyc(0, 0, 1, 0, 0);
      chk("R1 order", int'(dout), int'(pat(n)));
      chk((D - 1 - n) < 64 ? "R4 pop code" : "R5 pop code", int'(pop_lvl), int'(exp_pop(D - 1 - n)));
      chk((n + 1) < 64 ? "R3 push code" : "R2 push code", int'(push_lvl), int'(exp_push(n + 1)));
      push_seen[push_lvl] = 1'b1; pop_seen[pop_lvl] = 1'b1;
    end
    chk("R6 push codes used", int'(push_seen), 32'hFC1F);
    chk("R6 pop codes used", int'(pop_seen), 32'hE17F);

    // R8 pop while empty
    cyc(0, 0, 1, 0, 0);
    chk("R8 dout held on empty pop", int'(dout), int'(pat(D - 1)));
    chk("R8 pop_lvl on empty pop", int'(pop_lvl), 0);
    cyc(1, 16'h1234, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R8 next word after empty pop", int'(dout), 16'h1234);

    // R10 flush
    for (int i = 0; i < 10; i++) cyc(1, 16'(i), 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R10 pop_flush pop_lvl", int'(pop_lvl), 0);
    chk("R10 pop_flush push_lvl", int'(push_lvl), 1);
    for (int i = 0; i < 5; i++) cyc(1, 16'(i), 0, 0, 0);
    cyc(1, 16'h0BEE, 0, 1, 0);
    chk("R10 push_flush keeps same-edge push", int'(pop_lvl), 1);
    cyc(0, 0, 1, 0, 0);
    chk("R10 surviving word", int'(dout), 16'h0BEE);

    // R11 clock enables
    push_ce = 0;
    cyc(1, 16'h7777, 0, 0, 0);
    chk("R11 push ignored with push_ce low", int'(pop_lvl), 0);
    push_ce = 1;
    cyc(1, 16'h4242, 0, 0, 0);
    pop_ce = 0;
    cyc(0, 0, 1, 0, 1);
    chk("R11 pop/flush ignored with pop_ce low", int'(pop_lvl), 1);
    pop_ce = 1;
    push_ce = 0;
    cyc(0, 0, 0, 1, 0);
    chk("R11 push_flush ignored with push_ce low", int'(pop_lvl), 1);
    push_ce = 1;

    // R12 asynchronous reset without an edge
    cyc(1, 1, 0, 0, 0);
    cyc(1, 2, 0, 0, 0);
    @(negedge clk); #1 arst_n = 0;
    #1;
    chk("R12 push_lvl after async reset", int'(push_lvl), 1);
    chk("R12 pop_lvl after async reset", int'(pop_lvl), 0);
    @(negedge clk); arst_n = 1;

    // R13 asynchronous instance
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); a_push = 1; a_din = pat(i + 100);
      @(posedge clk); #1 a_push = 0;
    end
    repeat (10) @(posedge pclk);
    #1;
    chk("R13 async pop_lvl settles", int'(a_qlvl), int'(exp_pop(20)));
    chk("R13 async push_lvl", int'(a_plvl), int'(exp_push(D - 20)));
    for (int i = 0; i < 20; i++) begin
      @(negedge pclk); a_pop = 1;
      @(posedge pclk); #1 a_pop = 0;
      chk("R13 async order", int'(a_dout), int'(pat(i + 100)));
    end
    repeat (10) @(posedge clk);
    #1;
    chk("R13 async push_lvl empty", int'(a_plvl), 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); a_push = 1; a_din = 16'(i);
      @(posedge clk); #1 a_push = 0;
    end
    repeat (10) @(posedge pclk);
    #1;
    chk("R13 async count before flush", int'(a_qlvl), int'(exp_pop(5)));
    @(negedge clk); a_pf = 1;
    @(posedge clk); #1 a_pf = 0;
    repeat (10) @(posedge pclk);
    #1;
    chk("R10 async push_flush empties read side", int'(a_qlvl), 0);
    repeat (10) @(posedge clk);
    #1;
    chk("R10 async push_flush write side", int'(a_plvl), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule